// File: doc/BRIEF.md
# Banked Interrupt Controller with Per-Source Clear Registers

This block gathers up to 33 peripheral interrupt lines into three 16-bit banks and presents them to a processor through a single-cycle register port. Source number n sits in bank n/16 at bit n%16. Each bank has a read-only status register and a read/write enable mask. The block drives two registered request lines: a normal request and a fast request.

Sources come in two kinds. Event sources latch a pending bit on a rising input and hold it until software writes to an address reserved for that one source. Condition sources, such as FIFO fill thresholds, show their input directly, one cycle late. Three fixed sources (1, 3 and 32) feed only the fast request line. Every other implemented source feeds the normal line. Software reads a bank's status, ANDs it with the mask, and services the highest set bit first, bank 0 before bank 1. That dispatch lives outside this block.

Top module: `banked_intc`

## Requirements
- R1: The status register of bank b is at 0x0240 + b*0x1000 and its mask register is at 0x0280 + b*0x1000, for b = 0..2. Source n appears at bit n%16 of bank n/16. A mask write takes effect at the clock edge that accepts it and reads back unchanged.
- R2: After reset every mask bit is zero and both request outputs are low.
- R3: An event source (1, 3, 4, 8, 9, 10, 11, 14, 15, 16) sets its status bit when its input is low at one clock edge and high at the next. The bit is visible from that edge onward and stays set after the input falls.
- R4: A write with any data to a source's own clear address removes that source's pending bit and no other. The clear addresses are 1:0x0600, 3:0x0640, 11:0x0680, 8:0x06C0, 9:0x0700, 10:0x0740, 14:0x0780, 4:0x07C0, 15:0x1600 and 16:0x1700. An input held high does not set the bit again.
- R5: If a rising edge and a clear write for the same source land on the same clock edge, the bit ends up set.
- R6: A condition source (5, 6, 7, 12, 13, 17, 18, 28, 29, 32) shows as its status bit the input value sampled at the previous clock edge.
- R7: The status bits of unimplemented sources (0, 2, 19 to 27, 30, 31) always read zero and never raise a request, whatever their inputs do.
- R8: The normal request output is high exactly when, one edge earlier, some source other than 1, 3 and 32 had both its status bit and its mask bit set.
- R9: Sources 1, 3 and 32, when set and unmasked, raise only the fast request output, which is registered in the same way as the normal one.
- R10: Writes to status addresses change no state, and reads of any address that is not a status or mask register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 33 | Peripheral interrupt inputs, bit n is source n |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the access |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
A wrong pending bit shows in the status read one cycle after the input edge or clear write. It reaches the request lines one edge after that. A clear that hits the wrong source shows up as a neighbour bit disappearing on the very next status read. A routing error in the fast set shows as the wrong request line rising two edges after the input. A mask register that leaks a write to a status address is caught on the next read of that mask.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int ADDR_W = 16;

  typedef enum logic [1:0] {
    SRC_UNUSED,
    SRC_LEVEL,
    SRC_LATCH
  } src_kind_e;

  // How each source number behaves.
  function automatic src_kind_e kind_of(input int n);
    case (n)
      1, 3, 4, 8, 9, 10, 11, 14, 15, 16: kind_of = SRC_LATCH;
      5, 6, 7, 12, 13, 17, 18, 28, 29, 32: kind_of = SRC_LEVEL;
      default: kind_of = SRC_UNUSED;
    endcase
  endfunction

  // Sources that feed the fast request line.
  function automatic logic is_fast(input int n);
    is_fast = (n == 1) || (n == 3) || (n == 32);
  endfunction

  // Per-source clear address; only meaningful for latched sources.
  function automatic logic [ADDR_W-1:0] clear_addr_of(input int n);
    case (n)
      1:  clear_addr_of = 16'h0600;
      3:  clear_addr_of = 16'h0640;
      4:  clear_addr_of = 16'h07C0;
      8:  clear_addr_of = 16'h06C0;
      9:  clear_addr_of = 16'h0700;
      10: clear_addr_of = 16'h0740;
      11: clear_addr_of = 16'h0680;
      14: clear_addr_of = 16'h0780;
      15: clear_addr_of = 16'h1600;
      16: clear_addr_of = 16'h1700;
      default: clear_addr_of = '0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] stat_addr_of(input int b);
    stat_addr_of = 16'h0240 | ADDR_W'(b << 12);
  endfunction

  function automatic logic [ADDR_W-1:0] mask_addr_of(input int b);
    mask_addr_of = 16'h0280 | ADDR_W'(b << 12);
  endfunction

  // Bit map of implemented sources (up to 64 bit positions).
  function automatic logic [63:0] impl_map(input int nsrc);
    impl_map = '0;
    for (int i = 0; i < 64; i++)
      if (i < nsrc && kind_of(i) != SRC_UNUSED) impl_map[i] = 1'b1;
  endfunction

  // Bit map of implemented fast sources.
  function automatic logic [63:0] fast_map(input int nsrc);
    fast_map = '0;
    for (int i = 0; i < 64; i++)
      if (i < nsrc && is_fast(i)) fast_map[i] = 1'b1;
  endfunction

endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell #(
  parameter bit IS_LATCH = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic clr_i,
  output logic status_o
);

  logic samp_q;
  logic hold_q;
  logic rise_w;
  logic hold_d;

  // Rising edge: high now, low at the previous edge.
  assign rise_w = src_i & ~samp_q;
  // Set has priority over a clear in the same cycle.
  assign hold_d = IS_LATCH ? (rise_w | (hold_q & ~clr_i)) : src_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      samp_q <= src_i;
      hold_q <= hold_d;
    end
  end

  assign status_o = hold_q;

  generate
    if (IS_LATCH) begin : g_latch_chk
      AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i && !samp_q) |=> status_o);  // R3
      AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !clr_i) |=> status_o);  // R3
      AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(src_i && !samp_q)) |=> !status_o);  // R4
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && src_i && !samp_q) |=> status_o);  // R5
    end else begin : g_level_chk
      AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (status_o == $past(src_i)));  // R6
    end
  endgenerate

endmodule

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
  parameter int BANK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] mask_o
);

  logic [BANK_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else if (wr_en) mask_q <= wdata;
  end

  assign mask_o = mask_q;

  AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mask_o == $past(wdata)));  // R1
  AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_o));  // R10

endmodule

// File: rtl/intc_regif.sv
module intc_regif
  import intc_pkg::*;
#(
  parameter int NUM_SRC  = 33,
  parameter int BANK_W   = 16,
  parameter int NUM_BANK = 3,
  localparam int TOT_W   = NUM_BANK * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [TOT_W-1:0]  status_i,
  input  logic [TOT_W-1:0]  mask_i,
  output logic [NUM_BANK-1:0] mask_wr_o,
  output logic [NUM_SRC-1:0]  clr_o,
  output logic [BANK_W-1:0]   rdata_o
);

  logic wr_w;
  assign wr_w = bus_sel & bus_we;

  // Mask write strobes, one per bank.
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_mask_dec
    assign mask_wr_o[b] = wr_w && (bus_addr == mask_addr_of(b));
  end

  // Clear strobes, only for latched sources.
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_clr_dec
    if (kind_of(n) == SRC_LATCH) begin : g_has
      assign clr_o[n] = wr_w && (bus_addr == clear_addr_of(n));
    end else begin : g_none
      assign clr_o[n] = 1'b0;
    end
  end

  // Read mux; unmapped addresses return zero.
  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANK; b++) begin
      if (bus_addr == stat_addr_of(b)) rdata_o = status_i[b*BANK_W +: BANK_W];
      if (bus_addr == mask_addr_of(b)) rdata_o = mask_i[b*BANK_W +: BANK_W];
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mask_wr_o, clr_o}));  // R4

endmodule

// File: rtl/intc_out_stage.sv
module intc_out_stage #(
  parameter int             TOT_W    = 48,
  parameter logic [TOT_W-1:0] FAST_MAP = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TOT_W-1:0] status_i,
  input  logic [TOT_W-1:0] mask_i,
  output logic             irq_o,
  output logic             fiq_o
);

  logic [TOT_W-1:0] live_w;
  logic             irq_d;
  logic             fiq_d;

  assign live_w = status_i & mask_i;
  assign irq_d  = |(live_w & ~FAST_MAP);
  assign fiq_d  = |(live_w & FAST_MAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= irq_d;
      fiq_o <= fiq_d;
    end
  end

  AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_i) == '0) |-> (!irq_o && !fiq_o));  // R8
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(mask_i & ~FAST_MAP)));  // R8
  AST_FIQ_FROM_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> $past(|(status_i & FAST_MAP)));  // R9

endmodule

// File: rtl/banked_intc.sv
module banked_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC  = 33,
  parameter int BANK_W   = 16,
  parameter int NUM_BANK = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BANK_W-1:0]   bus_wdata,
  output logic [BANK_W-1:0]   bus_rdata,
  output logic                irq_o,
  output logic                fiq_o
);

  localparam int          TOT_W    = NUM_BANK * BANK_W;
  localparam logic [63:0] IMPL_ALL = impl_map(NUM_SRC);
  localparam logic [63:0] FAST_ALL = fast_map(NUM_SRC);
  localparam logic [TOT_W-1:0] IMPL_MAP = IMPL_ALL[TOT_W-1:0];
  localparam logic [TOT_W-1:0] FAST_MAP = FAST_ALL[TOT_W-1:0];

  logic [TOT_W-1:0]    raw_st;
  logic [TOT_W-1:0]    status_v;
  logic [TOT_W-1:0]    mask_v;
  logic [NUM_SRC-1:0]  clr_v;
  logic [NUM_BANK-1:0] mask_wr;

  // One cell per bit position; unimplemented ones are cut off by IMPL_MAP
  // and their flops fall away in synthesis.
  for (genvar n = 0; n < TOT_W; n++) begin : g_src
    if (n < NUM_SRC) begin : g_cell
      intc_src_cell #(
        .IS_LATCH(kind_of(n) == SRC_LATCH)
      ) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i[n]),
        .clr_i   (clr_v[n]),
        .status_o(raw_st[n])
      );
    end else begin : g_pad
      assign raw_st[n] = 1'b0;
    end
  end

  assign status_v = raw_st & IMPL_MAP;

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    intc_mask_bank #(
      .BANK_W(BANK_W)
    ) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (mask_wr[b]),
      .wdata (bus_wdata),
      .mask_o(mask_v[b*BANK_W +: BANK_W])
    );
  end

  intc_regif #(
    .NUM_SRC (NUM_SRC),
    .BANK_W  (BANK_W),
    .NUM_BANK(NUM_BANK)
  ) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .status_i (status_v),
    .mask_i   (mask_v),
    .mask_wr_o(mask_wr),
    .clr_o    (clr_v),
    .rdata_o  (bus_rdata)
  );

  intc_out_stage #(
    .TOT_W   (TOT_W),
    .FAST_MAP(FAST_MAP)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .status_i(status_v),
    .mask_i  (mask_v),
    .irq_o   (irq_o),
    .fiq_o   (fiq_o)
  );

endmodule

// File: tb/banked_intc_bench.sv
`timescale 1ns/1ps
module banked_intc_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [32:0] src = '0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, fiq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sbq[$];

  always #2.5 clk = ~clk;

  banked_intc u_banked_intc (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected value for each read the driver issued.
  always @(negedge clk) begin
    rd_item_t it;
    if (bus_sel && !bus_we) begin
      if (sbq.size() == 0) begin
        check("scoreboard empty on read", 16'hxxxx, 16'h0000);
      end else begin
        it = sbq.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    tick();
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
    tick();
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    sbq.push_back('{exp, tag});
    tick();
    bus_sel = 1'b0;
  endtask

  task automatic set_src(input int n, input logic v);
    tick();
    src[n] = v;
  endtask

  task automatic chk_out(input logic ei, input logic ef, input string tag);
    tick();
    tick();
    check({tag, " irq"}, {15'b0, irq}, {15'b0, ei});
    check({tag, " fiq"}, {15'b0, fiq}, {15'b0, ef});
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2: reset state
    chk_out(1'b0, 1'b0, "R2 after reset");
    rd(16'h0280, 16'h0000, "R2 mask0 reset");
    rd(16'h1280, 16'h0000, "R2 mask1 reset");
    rd(16'h2280, 16'h0000, "R2 mask2 reset");

    // R10: unmapped reads
    rd(16'h0000, 16'h0000, "R10 unmapped 0x0000");
    rd(16'h0284, 16'h0000, "R10 unmapped 0x0284");

    // R1: mask read/write
    wr(16'h0280, 16'hFFFF);
    rd(16'h0280, 16'hFFFF, "R1 mask0 readback");

    // R6 / R8: level source 5
    set_src(5, 1'b1);
    rd(16'h0240, 16'h0020, "R6 src5 high");
    chk_out(1'b1, 1'b0, "R8 src5 request");
    set_src(5, 1'b0);
    rd(16'h0240, 16'h0000, "R6 src5 low");
    chk_out(1'b0, 1'b0, "R8 src5 released");

    // R3 / R4: latched source 11
    set_src(11, 1'b1);
    rd(16'h0240, 16'h0800, "R3 src11 set");
    set_src(11, 1'b0);
    rd(16'h0240, 16'h0800, "R3 src11 held");
    chk_out(1'b1, 1'b0, "R8 src11 request");
    wr(16'h0680, 16'h5A5A);
    rd(16'h0240, 16'h0000, "R4 src11 cleared");
    chk_out(1'b0, 1'b0, "R4 after clear");

    // R4: clear hits only its own source; held-high input does not re-set
    set_src(8, 1'b1);
    set_src(9, 1'b1);
    rd(16'h0240, 16'h0300, "R3 src8 src9 set");
    wr(16'h06C0, 16'h0000);
    rd(16'h0240, 16'h0200, "R4 only src8 cleared");
    wr(16'h0700, 16'hFFFF);
    rd(16'h0240, 16'h0000, "R4 src9 cleared");
    set_src(8, 1'b0);
    set_src(9, 1'b0);

    // R5: rising edge and clear on the same edge
    tick();
    src[8] = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 16'h06C0; bus_wdata = 16'h0000;
    tick();
    bus_sel = 1'b0; bus_we = 1'b0;
    rd(16'h0240, 16'h0100, "R5 set wins over clear");
    wr(16'h06C0, 16'h0000);
    rd(16'h0240, 16'h0000, "R4 src8 cleared later");
    set_src(8, 1'b0);

    // R9: fast source 1
    set_src(1, 1'b1);
    rd(16'h0240, 16'h0002, "R9 src1 status");
    chk_out(1'b0, 1'b1, "R9 src1 fast only");
    wr(16'h0600, 16'h0000);
    rd(16'h0240, 16'h0000, "R4 src1 cleared");
    chk_out(1'b0, 1'b0, "R9 src1 released");
    set_src(1, 1'b0);

    // R3 / R4: source 15 with clear in the second address page
    set_src(15, 1'b1);
    rd(16'h0240, 16'h8000, "R3 src15 set");
    wr(16'h1600, 16'h0000);
    rd(16'h0240, 16'h0000, "R4 src15 cleared");
    set_src(15, 1'b0);

    // R1 / R8: bank 1, masked then enabled
    set_src(16, 1'b1);
    rd(16'h1240, 16'h0001, "R1 src16 in bank1 bit0");
    chk_out(1'b0, 1'b0, "R8 src16 masked");
    wr(16'h1280, 16'h0001);
    chk_out(1'b1, 1'b0, "R8 src16 enabled");
    wr(16'h1700, 16'h0000);
    rd(16'h1240, 16'h0000, "R4 src16 cleared");
    chk_out(1'b0, 1'b0, "R8 src16 released");
    set_src(16, 1'b0);
    set_src(28, 1'b1);
    rd(16'h1240, 16'h1000, "R6 src28 bank1 bit12");
    set_src(28, 1'b0);

    // R1 / R9: bank 2 source 32
    wr(16'h2280, 16'h0001);
    set_src(32, 1'b1);
    rd(16'h2240, 16'h0001, "R1 src32 bank2 bit0");
    chk_out(1'b0, 1'b1, "R9 src32 fast only");
    set_src(32, 1'b0);
    rd(16'h2240, 16'h0000, "R6 src32 low");
    chk_out(1'b0, 1'b0, "R9 src32 released");

    // R10: status write ignored
    wr(16'h0240, 16'h1234);
    rd(16'h0280, 16'hFFFF, "R10 mask0 after status write");
    rd(16'h0240, 16'h0000, "R10 status0 after status write");

    // R7: unimplemented sources
    tick();
    src[0] = 1'b1; src[2] = 1'b1; src[30] = 1'b1; src[31] = 1'b1;
    for (int i = 19; i <= 27; i++) src[i] = 1'b1;
    rd(16'h0240, 16'h0000, "R7 bank0 unused bits");
    wr(16'h1280, 16'hFFFF);
    rd(16'h1240, 16'h0000, "R7 bank1 unused bits");
    chk_out(1'b0, 1'b0, "R7 no request");

    check("R1 scoreboard drained", 16'(sbq.size()), 16'h0000);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule